// File: doc/BRIEF.md
# Data Space Decoder with External SRAM Bus

This block sits between a CPU core's load/store unit and the memories behind one flat 16-bit byte address space. Each cycle the core presents an address, a read/write flag, a write byte and a valid flag. The block decides which of four regions the address falls in: the 32-entry register file, the 64-entry I/O register bank, a 512-byte on-chip SRAM, or an external asynchronous SRAM bus. It then raises the matching select with a region-relative index, or runs a strobed cycle on the external bus.

On-chip accesses finish in the cycle they are presented. External accesses are stretched. The core sees `req_ready` low and must hold its request steady until `req_ready` goes high. During that window the block drives the external address, the write byte and an active-low read or write strobe. Two control inputs come from a core configuration register. One enables the external bus. The other adds a wait state to every external byte. With the bus disabled, accesses to the external region complete at once and do nothing.

Region bounds follow from the parameters: the register file starts at 0x0000, the I/O bank at 0x0020, the on-chip SRAM at 0x0060, and the external region at 0x0260 and runs up to 0xFFFF.

Top module: `dspace_router`

## Requirements
- R1: A valid access to 0x0000–0x001F raises `reg_sel` with `reg_idx` equal to the address. `reg_idx` is 0 whenever `reg_sel` is low.
- R2: A valid access to 0x0020–0x005F raises `io_sel` with `io_idx` equal to the address minus 0x20. `io_idx` is 0 whenever `io_sel` is low.
- R3: A valid access to 0x0060–0x025F raises `sram_sel` with `sram_addr` equal to the address minus 0x60. `sram_addr` is 0 whenever `sram_sel` is low.
- R4: An on-chip access has `req_ready` high in the same cycle. A read returns the selected region's read byte on `req_rdata` in that cycle. `int_we` is high exactly for valid on-chip writes. `req_rdata` is 0x00 in every cycle that is not a completing read.
- R5: `ext_rd_n` and `ext_wr_n` stay high in idle cycles and during any access to the register file, the I/O bank or the on-chip SRAM.
- R6: With the external bus enabled and no wait state, an access at 0x0260 or above holds `req_ready` low for its first cycle and raises it in its second. The access lasts two cycles.
- R7: Throughout an external window, `ext_addr` equals the request address and exactly one strobe is low: `ext_rd_n` for a read, `ext_wr_n` for a write. `ext_dout` carries the write byte during a write window. Outside a window, both `ext_addr` and `ext_dout` are 0.
- R8: An external read returns `ext_din` on `req_rdata` in the window's final cycle, the cycle in which `req_ready` is high.
- R9: With the external bus disabled, an access to the external region completes in one cycle and raises no strobe, no select and no `int_we`. A read returns 0x00.
- R10: With `xmem_wait` high, an external access lasts three cycles, and its strobe stays low through all three.
- R11: Two external byte accesses presented back to back take four cycles in total, one extra cycle for each byte.
- R12: At most one of `reg_sel`, `io_sel`, `sram_sel` and an active external strobe is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xmem_en | input | 1 | External bus enable |
| xmem_wait | input | 1 | Adds one wait state per external byte |
| req_valid | input | 1 | Core access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Data space byte address |
| req_wdata | input | 8 | Store byte |
| req_ready | output | 1 | Access completes this cycle (low = stall) |
| req_rdata | output | 8 | Load byte on a completing read, else 0 |
| reg_sel | output | 1 | Register file select |
| reg_idx | output | 5 | Register index |
| reg_rdata | input | 8 | Register file read byte |
| io_sel | output | 1 | I/O bank select |
| io_idx | output | 6 | I/O register index |
| io_rdata | input | 8 | I/O bank read byte |
| sram_sel | output | 1 | On-chip SRAM select |
| sram_addr | output | 9 | On-chip SRAM byte address |
| sram_rdata | input | 8 | On-chip SRAM read byte |
| int_we | output | 1 | Write enable for the selected on-chip target |
| int_wdata | output | 8 | Write byte to on-chip targets |
| ext_addr | output | 16 | External bus address |
| ext_dout | output | 8 | External bus write byte |
| ext_din | input | 8 | External bus read byte |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The hardest situation to reach is a chain of external accesses with no idle cycle between them. There the strobe stays low across the boundary, and only `req_ready` marks where one byte ends and the next begins. The stimulus gets there by issuing the second request on the clock edge right after the first one completes. This is done with and without the wait state, and once more with a read following a write. The stimulus also places accesses on every region's first and last address, so that off-by-one decoding at 0x001F/0x0020, 0x005F/0x0060 and 0x025F/0x0260 shows up in the selects or the strobes.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
  typedef enum logic [1:0] {
    RGN_REG  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_SRAM = 2'd2,
    RGN_EXT  = 2'd3
  } region_e;
endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
  import dspace_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int REG_CNT    = 32,
  parameter int IO_CNT     = 64,
  parameter int SRAM_BYTES = 512,
  localparam int REG_W     = $clog2(REG_CNT),
  localparam int IO_W      = $clog2(IO_CNT),
  localparam int SRAM_W    = $clog2(SRAM_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [REG_W-1:0]  reg_idx,
  output logic [IO_W-1:0]   io_idx,
  output logic [SRAM_W-1:0] sram_off
);
  localparam int IO_BASE   = REG_CNT;
  localparam int SRAM_BASE = REG_CNT + IO_CNT;
  localparam int EXT_BASE  = SRAM_BASE + SRAM_BYTES;

  always_comb begin
    if (addr < ADDR_W'(IO_BASE))        region = RGN_REG;
    else if (addr < ADDR_W'(SRAM_BASE)) region = RGN_IO;
    else if (addr < ADDR_W'(EXT_BASE))  region = RGN_SRAM;
    else                                region = RGN_EXT;
  end

  assign reg_idx  = REG_W'(addr);
  assign io_idx   = IO_W'(addr - ADDR_W'(IO_BASE));
  assign sram_off = SRAM_W'(addr - ADDR_W'(SRAM_BASE));
endmodule

// File: rtl/dspace_ext_seq.sv
module dspace_ext_seq #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic wait_en,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;

  assign need = wait_en ? CNT_W'(2) : CNT_W'(1);
  assign done = go && (cnt_q == need);

  always_ff @(posedge clk) begin
    if (rst || !go || done) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/dspace_rdmux.sv
module dspace_rdmux
  import dspace_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  region_e           region,
  input  logic              ext_ok,
  input  logic [DATA_W-1:0] reg_rd,
  input  logic [DATA_W-1:0] io_rd,
  input  logic [DATA_W-1:0] sram_rd,
  input  logic [DATA_W-1:0] ext_rd,
  output logic [DATA_W-1:0] rd
);
  always_comb begin
    unique case (region)
      RGN_REG:  rd = reg_rd;
      RGN_IO:   rd = io_rd;
      RGN_SRAM: rd = sram_rd;
      default:  rd = ext_ok ? ext_rd : '0;
    endcase
  end
endmodule

// File: rtl/dspace_router.sv
module dspace_router
  import dspace_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int REG_CNT    = 32,
  parameter int IO_CNT     = 64,
  parameter int SRAM_BYTES = 512,
  localparam int REG_W     = $clog2(REG_CNT),
  localparam int IO_W      = $clog2(IO_CNT),
  localparam int SRAM_W    = $clog2(SRAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xmem_en,
  input  logic              xmem_wait,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  output logic              reg_sel,
  output logic [REG_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              io_sel,
  output logic [IO_W-1:0]   io_idx,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              sram_sel,
  output logic [SRAM_W-1:0] sram_addr,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              int_we,
  output logic [DATA_W-1:0] int_wdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_dout,
  input  logic [DATA_W-1:0] ext_din,
  output logic              ext_rd_n,
  output logic              ext_wr_n
);
  region_e           region;
  logic [REG_W-1:0]  dec_reg;
  logic [IO_W-1:0]   dec_io;
  logic [SRAM_W-1:0] dec_sram;
  logic              on_chip, ext_go, ext_done;
  logic [DATA_W-1:0] mux_rd;

  dspace_decode #(
    .ADDR_W(ADDR_W), .REG_CNT(REG_CNT), .IO_CNT(IO_CNT), .SRAM_BYTES(SRAM_BYTES)
  ) u_decode (
    .addr(req_addr), .region(region),
    .reg_idx(dec_reg), .io_idx(dec_io), .sram_off(dec_sram)
  );

  assign on_chip = req_valid && (region != RGN_EXT);
  assign ext_go  = req_valid && (region == RGN_EXT) && xmem_en;

  dspace_ext_seq #(.CNT_W(2)) u_seq (
    .clk(clk), .rst(rst), .go(ext_go), .wait_en(xmem_wait), .done(ext_done)
  );

  dspace_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .region(region), .ext_ok(xmem_en),
    .reg_rd(reg_rdata), .io_rd(io_rdata), .sram_rd(sram_rdata), .ext_rd(ext_din),
    .rd(mux_rd)
  );

  assign req_ready = !ext_go || ext_done;
  assign req_rdata = (req_valid && !req_write && req_ready) ? mux_rd : '0;

  assign reg_sel   = req_valid && (region == RGN_REG);
  assign io_sel    = req_valid && (region == RGN_IO);
  assign sram_sel  = req_valid && (region == RGN_SRAM);
  assign reg_idx   = reg_sel  ? dec_reg  : '0;
  assign io_idx    = io_sel   ? dec_io   : '0;
  assign sram_addr = sram_sel ? dec_sram : '0;
  assign int_we    = on_chip && req_write;
  assign int_wdata = req_wdata;

  assign ext_addr  = ext_go ? req_addr : '0;
  assign ext_dout  = (ext_go && req_write) ? req_wdata : '0;
  assign ext_rd_n  = !(ext_go && !req_write);
  assign ext_wr_n  = !(ext_go && req_write);
endmodule

// File: rtl/dspace_router_chk.sv
module dspace_router_chk #(
  parameter int ADDR_W   = 16,
  parameter int EXT_BASE = 608
) (
  input logic              clk,
  input logic              rst,
  input logic              xmem_en,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic [7:0]        req_rdata,
  input logic              reg_sel,
  input logic              io_sel,
  input logic              sram_sel,
  input logic              ext_rd_n,
  input logic              ext_wr_n
);
  logic in_ext, strobe;
  assign in_ext = req_valid && (req_addr >= ADDR_W'(EXT_BASE));
  assign strobe = !ext_rd_n || !ext_wr_n;

  a_r4_onchip_ready: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_ext) |-> req_ready);

  a_r5_strobe_only_ext: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (in_ext && xmem_en));

  a_r6_first_cycle_stall: assert property (@(posedge clk) disable iff (rst)
    (in_ext && xmem_en && !$past(strobe)) |-> !req_ready);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!ext_rd_n && !ext_wr_n));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_ext && !xmem_en) |-> (req_ready && req_rdata == 8'h00 && !strobe));

  a_r12_onehot_targets: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_sel, io_sel, sram_sel, strobe}));
endmodule

bind dspace_router dspace_router_chk #(
  .ADDR_W(ADDR_W), .EXT_BASE(REG_CNT + IO_CNT + SRAM_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .xmem_en(xmem_en), .req_valid(req_valid),
  .req_addr(req_addr), .req_ready(req_ready), .req_rdata(req_rdata),
  .reg_sel(reg_sel), .io_sel(io_sel), .sram_sel(sram_sel),
  .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
);

// File: tb/test_dspace_router.sv
module test_dspace_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xmem_en = 1'b0, xmem_wait = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready;
  logic [7:0] req_rdata;
  logic reg_sel, io_sel, sram_sel, int_we, ext_rd_n, ext_wr_n;
  logic [4:0] reg_idx;
  logic [5:0] io_idx;
  logic [8:0] sram_addr;
  logic [7:0] reg_rdata, io_rdata, sram_rdata, int_wdata, ext_dout, ext_din;
  logic [15:0] ext_addr;

  int checks = 0, fails = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  assign reg_rdata  = {3'b000, reg_idx} ^ 8'hA5;
  assign io_rdata   = {2'b00, io_idx} + 8'h40;
  assign sram_rdata = sram_addr[7:0] ^ 8'h3C;
  assign ext_din    = ext_addr[7:0] ^ ext_addr[15:8];

  dspace_router i_dspace_router (
    .clk(clk), .rst(rst), .xmem_en(xmem_en), .xmem_wait(xmem_wait),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_rdata(reg_rdata),
    .io_sel(io_sel), .io_idx(io_idx), .io_rdata(io_rdata),
    .sram_sel(sram_sel), .sram_addr(sram_addr), .sram_rdata(sram_rdata),
    .int_we(int_we), .int_wdata(int_wdata),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: region from address ranges, stall length from the enable and wait bits
  function automatic int region_of(input int a);
    if (a < 32) return 0;
    if (a < 96) return 1;
    if (a < 608) return 2;
    return 3;
  endfunction

  function automatic bit m_active();
    return req_valid && region_of(int'(req_addr)) == 3 && xmem_en;
  endfunction

  function automatic bit m_ready();
    return !m_active() || (m_cnt == (xmem_wait ? 2 : 1));
  endfunction

  always @(posedge clk) begin
    if (rst || !m_active() || m_ready()) m_cnt = 0;
    else m_cnt = m_cnt + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      int r, a, exp_rd;
      bit act, rdy;
      a = int'(req_addr);
      r = region_of(a);
      act = m_active();
      rdy = m_ready();
      chk("R1 reg_sel", reg_sel, req_valid && r == 0);
      chk("R1 reg_idx", reg_idx, (req_valid && r == 0) ? a : 0);
      chk("R2 io_sel", io_sel, req_valid && r == 1);
      chk("R2 io_idx", io_idx, (req_valid && r == 1) ? a - 32 : 0);
      chk("R3 sram_sel", sram_sel, req_valid && r == 2);
      chk("R3 sram_addr", sram_addr, (req_valid && r == 2) ? a - 96 : 0);
      chk("R4 int_we", int_we, req_valid && req_write && r != 3);
      chk("R6 R10 req_ready", req_ready, rdy);
      chk("R5 R7 ext_rd_n", ext_rd_n, !(act && !req_write));
      chk("R5 R7 ext_wr_n", ext_wr_n, !(act && req_write));
      chk("R7 ext_addr", ext_addr, act ? a : 0);
      chk("R7 ext_dout", ext_dout, (act && req_write) ? int'(req_wdata) : 0);
      exp_rd = 0;
      if (req_valid && !req_write && rdy) begin
        case (r)
          0: exp_rd = (a ^ 'hA5) & 'hFF;
          1: exp_rd = (a - 32 + 'h40) & 'hFF;
          2: exp_rd = ((a - 96) ^ 'h3C) & 'hFF;
          default: exp_rd = xmem_en ? ((a & 'hFF) ^ (a >> 8)) : 0;
        endcase
      end
      chk("R4 R8 R9 req_rdata", req_rdata, exp_rd);
    end
  end

  // Presents one access on the next edge and returns the cycles until ready
  task automatic acc(input bit wr, input int a, input int d, output int lat);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = 16'(a); req_wdata = 8'(d);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (req_ready) break;
      if (lat > 10) break;
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic one(input string req, input bit wr, input int a, input int d, input int exp_lat);
    int lat;
    acc(wr, a, d, lat);
    chk(req, lat, exp_lat);
    idle();
  endtask

  initial begin
    int l1, l2;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R5 reset strobes", {ext_rd_n, ext_wr_n}, 2'b11);
    chk("R4 reset ready", req_ready, 1);

    // On-chip regions, edges of each range
    one("R1 latency", 0, 16'h0000, 0, 1);
    one("R1 latency", 1, 16'h001F, 8'h11, 1);
    one("R2 latency", 0, 16'h0020, 0, 1);
    one("R2 latency", 1, 16'h005F, 8'h22, 1);
    one("R3 latency", 0, 16'h0060, 0, 1);
    one("R3 latency", 0, 16'h025F, 0, 1);
    one("R3 latency", 1, 16'h0155, 8'h33, 1);

    // External bus disabled
    one("R9 latency", 0, 16'h0260, 0, 1);
    one("R9 latency", 1, 16'hFFFF, 8'h44, 1);

    // External enabled
    @(posedge clk); #1 xmem_en = 1'b1;
    one("R5 onchip with en", 0, 16'h025F, 0, 1);
    one("R6 latency", 0, 16'h0260, 0, 2);
    one("R6 latency", 1, 16'hFFFF, 8'h5A, 2);
    one("R8 latency", 0, 16'hABCD, 0, 2);

    // Two bytes back to back
    acc(1, 16'h8000, 8'h12, l1);
    acc(1, 16'h8001, 8'h34, l2);
    chk("R11 two-byte cycles", l1 + l2, 4);
    acc(1, 16'h1234, 8'h56, l1);
    acc(0, 16'h1235, 0, l2);
    chk("R11 write then read", l1 + l2, 4);
    idle();

    // Wait state
    @(posedge clk); #1 xmem_wait = 1'b1;
    one("R10 latency", 0, 16'h0300, 0, 3);
    one("R10 latency", 1, 16'hC001, 8'h99, 3);
    acc(0, 16'h4000, 0, l1);
    acc(0, 16'h4001, 0, l2);
    chk("R10 R11 chained", l1 + l2, 6);
    idle();
    one("R4 onchip with wait", 1, 16'h0030, 8'h77, 1);

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule